// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing front end of a byte-addressed serial memory. It watches an oversampled two-wire clock and data pair and recognises the bus framing conditions. It shifts in bytes MSB first on rising clock edges and changes its own data drive only after falling clock edges, through an open-drain enable. It matches the device address against a fixed four-bit code and three strapped pins, and produces the ninth-bit acknowledge.

After a write-direction device address, the block collects two word-address bytes, high byte first, and hands the result to an external word-address counter. Each following data byte goes out as a valid/ready stream to a write-page controller. That controller gets a commit pulse when the master ends the transfer with a stop, and a cancel pulse if a new start arrives instead. A read-direction device address fetches bytes from a read-data stream at the counter's current position. The block keeps sending bytes for as long as the master acknowledges them. A random read is a dummy write of the word address, followed by a repeated start.

Stream rules: a write byte is offered from the rising edge of its eighth bit and held until accepted or until the acknowledge slot opens. An accepted byte is acknowledged. A byte not taken by then is dropped and refused. The read port is asked for a byte (`rd_ready`) during the acknowledge slot before each read byte. If no byte is delivered before that slot closes, all ones go out and nothing is consumed. While the external write cycle is busy, the device address is refused, so the master can poll for completion.

Top module: `twi_mem_slave`

## Requirements
- R1: A start (SDA falling while SCL high) in any state restarts device-address reception; a stop (SDA rising while SCL high) returns the block to idle, where bus bits are ignored until the next start.
- R2: The device address byte is MSB first: bits 7:4 must equal DEV_CODE (default 4'b1010), bits 3:1 must equal `dev_pins`, and bit 0 is direction (1 = read). On a match, `sda_oe` is high during the ninth clock.
- R3: On a device-address mismatch, no acknowledge is given and the rest of the transfer is ignored (no acknowledge, no `wa_load`, no `wr_valid`) until the next start.
- R4: While `wr_busy` is high, a matching device address is not acknowledged; once it is low, the same address is acknowledged.
- R5: In a write, two word-address bytes (high, then low) are acknowledged. The low AW bits of {high, low} appear on `wa_value` with a single-cycle `wa_load`; upper bits are ignored.
- R6: Each write data byte appears on `wr_data` with `wr_valid`. It is held stable until `wr_ready`, and an accepted byte is acknowledged.
- R7: A write data byte not accepted before its acknowledge slot is refused (no acknowledge); `wr_valid` drops and later bytes of that transfer are ignored.
- R8: A stop after at least one accepted write byte gives one `wr_commit` pulse. A start in that situation gives one `wr_cancel` pulse instead. Neither pulses if no byte was accepted.
- R9: In a read, bytes taken from the read stream are sent MSB first, each bit driven after a falling SCL. The first byte is requested during the device-address acknowledge slot.
- R10: The read continues with the next streamed byte while the master drives 0 in the ninth clock. A master 1 there ends the read: no more requests and SDA stays released until the next start.
- R11: If no read byte has been delivered when the acknowledge slot closes, 8'hFF is sent and no read-stream byte is consumed.
- R12: `sda_oe` only rises while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| sda_oe | output | 1 | Pull SDA low when high |
| dev_pins | input | 3 | Strapped device address bits |
| wr_busy | input | 1 | External write cycle in progress |
| wa_load | output | 1 | Load word-address counter |
| wa_value | output | AW | Word address to load |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Write-page controller takes the byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | Start the internal write (stop seen) |
| wr_cancel | output | 1 | Discard buffered write bytes (start seen) |
| rd_valid | input | 1 | Read byte available |
| rd_ready | output | 1 | Block requests a read byte |
| rd_data | input | 8 | Read byte at the current word address |

## Verification
The bench sweeps every strapped-address value and a wrong device code. A comparator that ignored a bit would acknowledge a stranger's address, and a late mismatch exit would still load addresses from the following bytes. It aborts a transfer mid-byte with a repeated start and sends bits after a stop with no start. Bit counting that survived the abort, or a slave that woke without a start, shows up as a wrong or missing acknowledge. Sequential reads end with a master refusal, stream underrun and refused write bytes are exercised, and busy polling is checked. A design that fetched one byte too many, sent stale data instead of all ones, or committed a cancelled write changes the handshake, data or pulse counts.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_WAIT
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  logic [LINES-1:0] stage [STAGES];
  logic [LINES-1:0] prev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '1;
        else        stage[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '1;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= stage[STAGES-1];
  end

  assign lvl  = stage[STAGES-1];
  assign rise = stage[STAGES-1] & ~prev;
  assign fall = ~stage[STAGES-1] & prev;
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       start_det,
  input  logic       stop_det,
  output logic [7:0] rx_byte,
  output logic [3:0] bit_idx,
  output logic       byte_done,
  output logic       ack_open,
  output logic       ack_sample,
  output logic       ack_close,
  output logic       data_fall
);
  logic active, armed;
  logic live;

  assign live = active && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      armed   <= 1'b0;
      bit_idx <= '0;
      rx_byte <= '0;
    end else if (start_det) begin
      active  <= 1'b1;
      armed   <= 1'b0;
      bit_idx <= '0;
    end else if (stop_det) begin
      active  <= 1'b0;
      armed   <= 1'b0;
      bit_idx <= '0;
    end else if (active) begin
      if (scl_rise && armed && bit_idx < 4'd8)
        rx_byte <= {rx_byte[6:0], sda_lvl};
      if (scl_fall) begin
        if (!armed)               armed   <= 1'b1;
        else if (bit_idx == 4'd8) bit_idx <= '0;
        else                      bit_idx <= bit_idx + 4'd1;
      end
    end
  end

  assign byte_done  = live && scl_rise && bit_idx == 4'd7;
  assign ack_open   = live && scl_fall && bit_idx == 4'd7;
  assign ack_sample = live && scl_rise && bit_idx == 4'd8;
  assign ack_close  = live && scl_fall && bit_idx == 4'd8;
  assign data_fall  = live && scl_fall && bit_idx < 4'd7;
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter int         AW       = 16,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          byte_done,
  input  logic          ack_open,
  input  logic          ack_sample,
  input  logic          ack_close,
  input  logic          data_fall,
  input  logic [3:0]    bit_idx,
  input  logic [7:0]    rx_byte,
  input  logic          sda_lvl,
  input  logic [2:0]    dev_pins,
  input  logic          wr_busy,
  output logic          sda_oe,
  output logic          wa_load,
  output logic [AW-1:0] wa_value,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic          wr_commit,
  output logic          wr_cancel,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          rd_ready,
  output twi_state_e    st
);
  twi_state_e  nxt;
  logic [7:0]  addr_hi, tx, tx_next;
  logic        have, wr_took, wrote;
  logic        dev_hit, wr_hs, rd_hs;
  logic [15:0] full_addr;
  logic [3:0]  tx_sel;

  assign dev_hit   = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:1] == dev_pins) && !wr_busy;
  assign full_addr = {addr_hi, rx_byte};
  assign wr_hs     = wr_valid && wr_ready;
  assign rd_hs     = rd_ready && rd_valid;
  assign tx_next   = rd_hs ? rd_data : (have ? tx : 8'hFF);
  assign tx_sel    = 4'd6 - bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      sda_oe    <= 1'b0;
      wa_load   <= 1'b0;
      wa_value  <= '0;
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      wr_cancel <= 1'b0;
      rd_ready  <= 1'b0;
      addr_hi   <= '0;
      tx        <= '0;
      have      <= 1'b0;
      wr_took   <= 1'b0;
      wrote     <= 1'b0;
    end else begin
      wa_load   <= 1'b0;
      wr_commit <= 1'b0;
      wr_cancel <= 1'b0;
      if (start_det) begin
        st        <= ST_DEV;
        nxt       <= ST_DEV;
        sda_oe    <= 1'b0;
        wr_valid  <= 1'b0;
        rd_ready  <= 1'b0;
        have      <= 1'b0;
        wr_took   <= 1'b0;
        wr_cancel <= wrote;
        wrote     <= 1'b0;
      end else if (stop_det) begin
        st        <= ST_IDLE;
        nxt       <= ST_IDLE;
        sda_oe    <= 1'b0;
        wr_valid  <= 1'b0;
        rd_ready  <= 1'b0;
        have      <= 1'b0;
        wr_took   <= 1'b0;
        wr_commit <= wrote;
        wrote     <= 1'b0;
      end else begin
        if (wr_hs) begin
          wr_valid <= 1'b0;
          wr_took  <= 1'b1;
        end
        if (rd_hs) begin
          tx       <= rd_data;
          have     <= 1'b1;
          rd_ready <= 1'b0;
        end
        if (byte_done && st == ST_WR) begin
          wr_valid <= 1'b1;
          wr_took  <= 1'b0;
        end
        if (data_fall && st == ST_RD)
          sda_oe <= ~tx[tx_sel[2:0]];
        if (ack_open) begin
          unique case (st)
            ST_DEV: begin
              if (dev_hit) begin
                sda_oe   <= 1'b1;
                nxt      <= rx_byte[0] ? ST_RD : ST_AHI;
                rd_ready <= rx_byte[0];
                have     <= 1'b0;
              end else begin
                nxt <= ST_WAIT;
              end
            end
            ST_AHI: begin
              sda_oe  <= 1'b1;
              addr_hi <= rx_byte;
              nxt     <= ST_ALO;
            end
            ST_ALO: begin
              sda_oe   <= 1'b1;
              wa_load  <= 1'b1;
              wa_value <= full_addr[AW-1:0];
              nxt      <= ST_WR;
            end
            ST_WR: begin
              wr_valid <= 1'b0;
              if (wr_took || wr_hs) begin
                sda_oe <= 1'b1;
                wrote  <= 1'b1;
                nxt    <= ST_WR;
              end else begin
                nxt <= ST_WAIT;
              end
            end
            ST_RD: begin
              sda_oe <= 1'b0;
              nxt    <= ST_RD;
            end
            default: nxt <= st;
          endcase
        end
        if (ack_sample && st == ST_RD) begin
          if (!sda_lvl) rd_ready <= 1'b1;
          else          nxt      <= ST_WAIT;
        end
        if (ack_close) begin
          st       <= nxt;
          rd_ready <= 1'b0;
          have     <= 1'b0;
          if (nxt == ST_RD) begin
            sda_oe <= ~tx_next[7];
            tx     <= tx_next;
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int         AW          = 16,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [2:0]    dev_pins,
  input  logic          wr_busy,
  output logic          wa_load,
  output logic [AW-1:0] wa_value,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          wr_cancel,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [7:0]    rd_data
);
  localparam int LINES = 2;

  logic [LINES-1:0] lvl, rise, fall;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic start_det, stop_det;
  logic [7:0] rx_byte;
  logic [3:0] bit_idx;
  logic byte_done, ack_open, ack_sample, ack_close, data_fall;
  twi_state_e st;

  twi_line_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({scl_in, sda_in}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  assign scl_lvl   = lvl[1];
  assign sda_lvl   = lvl[0];
  assign scl_rise  = rise[1];
  assign scl_fall  = fall[1];
  assign start_det = fall[0] && scl_lvl && !scl_rise;
  assign stop_det  = rise[0] && scl_lvl && !scl_rise;

  twi_bit_engine u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rx_byte   (rx_byte),
    .bit_idx   (bit_idx),
    .byte_done (byte_done),
    .ack_open  (ack_open),
    .ack_sample(ack_sample),
    .ack_close (ack_close),
    .data_fall (data_fall)
  );

  twi_ctrl #(.AW(AW), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .byte_done (byte_done),
    .ack_open  (ack_open),
    .ack_sample(ack_sample),
    .ack_close (ack_close),
    .data_fall (data_fall),
    .bit_idx   (bit_idx),
    .rx_byte   (rx_byte),
    .sda_lvl   (sda_lvl),
    .dev_pins  (dev_pins),
    .wr_busy   (wr_busy),
    .sda_oe    (sda_oe),
    .wa_load   (wa_load),
    .wa_value  (wa_value),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_commit (wr_commit),
    .wr_cancel (wr_cancel),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_ready  (rd_ready),
    .st        (st)
  );

  assign wr_data = rx_byte;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       ack_open,
  input logic       sda_oe,
  input logic       wr_busy,
  input logic       wa_load,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic       wr_commit,
  input logic       rd_ready,
  input twi_state_e st
);
  assert_oe_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  assert_wa_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wa_load |=> !wa_load);

  assert_commit_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_det));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !ack_open && !start_det && !stop_det)
      |=> (wr_valid && $stable(wr_data)));

  assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_open && st == ST_DEV && wr_busy) |=> !sda_oe);

  assert_quiet_when_ignoring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT || st == ST_IDLE) |-> !sda_oe);

  assert_read_req_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (st == ST_RD || st == ST_DEV));
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .start_det(start_det),
  .stop_det (stop_det),
  .ack_open (ack_open),
  .sda_oe   (sda_oe),
  .wr_busy  (wr_busy),
  .wa_load  (wa_load),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_data  (wr_data),
  .wr_commit(wr_commit),
  .rd_ready (rd_ready),
  .st       (st)
);

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
  localparam int AW = 12;
  localparam int H  = 8;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wa_load, wr_valid, wr_commit, wr_cancel, rd_ready;
  logic [AW-1:0] wa_value;
  logic [7:0] wr_data, rd_data;
  logic wr_ready = 1'b1, rd_valid = 1'b1, wr_busy = 1'b0;
  logic sda_bus;
  logic [AW-1:0] rptr = '0;

  int n_checks = 0, n_fail = 0;
  int n_wa = 0, n_rd = 0, n_commit = 0, n_cancel = 0, n_wr = 0;
  logic [AW-1:0] last_wa = '0;
  logic [7:0] wbuf [16];
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return 8'((32'(a) * 37 + 11) & 32'hFF);
  endfunction

  assign rd_data = mem_f(rptr);

  twi_mem_slave #(.AW(AW)) i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .dev_pins(PINS), .wr_busy(wr_busy), .wa_load(wa_load), .wa_value(wa_value),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_cancel(wr_cancel),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (wa_load) begin
      rptr    <= wa_value;
      last_wa <= wa_value;
      n_wa++;
    end else if (rd_valid && rd_ready) begin
      rptr <= rptr + 1'b1;
      n_rd++;
    end
    if (wr_valid && wr_ready) begin
      wbuf[n_wr % 16] <= wr_data;
      n_wr++;
    end
    if (wr_commit) n_commit++;
    if (wr_cancel) n_cancel++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wt(H);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wt(H/2);
    sda_m = 1'b0; wt(H/2);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    wt(H/2); sda_m = b; wt(H/2);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wt(H/2); sda_m = 1'b1; wt(H/2);
    scl_m = 1'b1; wt(H/2);
    b = sda_bus; wt(H/2);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!mack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] a, input bit rd);
    return {4'b1010, a, rd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    int base;
    wt(5);
    check(sda_oe == 1'b0 && wa_load == 1'b0 && wr_valid == 1'b0 && rd_ready == 1'b0,
          "reset R12", int'(sda_oe), 0);
    rst_n = 1'b1;
    wt(5);

    // R2/R3: sweep strapped address bits and direction
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        bus_start();
        send_byte(dev(3'(a), d[0]), ack);
        check(ack == (a == int'(PINS)), "R2 address match", int'(ack), int'(a == int'(PINS)));
        if (d == 1 && ack) begin
          recv_byte(v, 1'b0);
        end
        bus_stop();
      end
    end
    // R3: wrong device code, later bytes ignored
    base = n_wa;
    bus_start();
    send_byte({4'b1011, PINS, 1'b0}, ack);
    check(!ack, "R3 wrong code nack", int'(ack), 0);
    send_byte(8'h01, ack);
    check(!ack, "R3 later byte ignored", int'(ack), 0);
    send_byte(8'h02, ack);
    bus_stop();
    check(n_wa == base, "R3 no address load", n_wa, base);

    // R5/R6/R8: write with address truncation
    base = n_wr;
    bus_start();
    send_byte(dev(PINS, 1'b0), ack);
    send_byte(8'hA1, ack);
    check(ack, "R5 high address ack", int'(ack), 1);
    send_byte(8'h23, ack);
    check(ack, "R5 low address ack", int'(ack), 1);
    check(last_wa == 12'h123, "R5 word address", int'(last_wa), 'h123);
    for (int i = 0; i < 8; i++) begin
      send_byte(8'(i * 29 + 5), ack);
      check(ack, "R6 data ack", int'(ack), 1);
    end
    bus_stop();
    wt(4);
    check(n_wr - base == 8, "R6 byte count", n_wr - base, 8);
    for (int i = 0; i < 8; i++)
      check(wbuf[(base + i) % 16] == 8'(i * 29 + 5), "R6 data value",
            int'(wbuf[(base + i) % 16]), (i * 29 + 5) & 255);
    check(n_commit == 1 && n_cancel == 0, "R8 commit on stop", n_commit, 1);

    // R7: refused write byte, no commit
    wr_ready = 1'b0;
    bus_start();
    send_byte(dev(PINS, 1'b0), ack);
    send_byte(8'h00, ack);
    send_byte(8'h40, ack);
    send_byte(8'h77, ack);
    check(!ack, "R7 unaccepted byte nack", int'(ack), 0);
    wr_ready = 1'b1;
    send_byte(8'h78, ack);
    check(!ack, "R7 later byte ignored", int'(ack), 0);
    bus_stop();
    wt(4);
    check(n_commit == 1, "R8 no commit without data", n_commit, 1);

    // R8: cancel by repeated start
    bus_start();
    send_byte(dev(PINS, 1'b0), ack);
    send_byte(8'h00, ack);
    send_byte(8'h50, ack);
    send_byte(8'h99, ack);
    bus_start();
    wt(4);
    check(n_cancel == 1 && n_commit == 1, "R8 cancel on start", n_cancel, 1);
    bus_stop();

    // R4: busy polling
    wr_busy = 1'b1;
    bus_start();
    send_byte(dev(PINS, 1'b0), ack);
    check(!ack, "R4 busy nack", int'(ack), 0);
    bus_stop();
    wr_busy = 1'b0;
    bus_start();
    send_byte(dev(PINS, 1'b0), ack);
    check(ack, "R4 ack after busy", int'(ack), 1);
    bus_stop();

    // R9/R10: random read across sequential bytes
    bus_start();
    send_byte(dev(PINS, 1'b0), ack);
    send_byte(8'h07, ack);
    send_byte(8'hF0, ack);
    bus_start();
    base = n_rd;
    send_byte(dev(PINS, 1'b1), ack);
    check(ack, "R9 read address ack", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(v, i < 3);
      check(v == mem_f(12'(12'h7F0 + i)), "R9 read data", int'(v), int'(mem_f(12'(12'h7F0 + i))));
    end
    bus_stop();
    check(n_rd - base == 4, "R10 fetch count", n_rd - base, 4);

    // R10: current address read continues from counter
    bus_start();
    send_byte(dev(PINS, 1'b1), ack);
    recv_byte(v, 1'b0);
    check(v == mem_f(12'h7F4), "R10 current address", int'(v), int'(mem_f(12'h7F4)));
    bus_stop();

    // R11: underrun sends all ones
    rd_valid = 1'b0;
    base = n_rd;
    bus_start();
    send_byte(dev(PINS, 1'b1), ack);
    recv_byte(v, 1'b0);
    bus_stop();
    rd_valid = 1'b1;
    check(v == 8'hFF, "R11 underrun data", int'(v), 'hFF);
    check(n_rd == base, "R11 nothing consumed", n_rd, base);

    // R1: abort mid-byte with a start
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(dev(PINS, 1'b1), ack);
    check(ack, "R1 restart after abort", int'(ack), 1);
    recv_byte(v, 1'b0);
    check(v == mem_f(12'h7F5), "R1 read after abort", int'(v), int'(mem_f(12'h7F5)));
    bus_stop();

    // R1: after stop, bits without a start are ignored
    send_byte(dev(PINS, 1'b0), ack);
    check(!ack, "R1 idle after stop", int'(ack), 0);
    bus_stop();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule